// File: doc/BRIEF.md
# Dual-Rail Masked Linear Gadget Set

This block is a set of combinational gates for data held as two Boolean shares. The first share is an ordinary bit. The second share travels as a pair of rails: a true rail that carries its value and a complement rail that carries its inverse. The block offers four gadgets:

- an inverter;
- an exclusive-OR;
- a two-way selector driven by a public select given as a rail pair;
- an exclusive-OR whose second operand can be forced to zero by a public enable given as a rail pair.

A shared datapath can use the selector and the gated exclusive-OR to serve both encryption and decryption. All four gadgets work lane by lane on vectors of parameter width `WIDTH`.

On the rail side only AND and OR gates are used, and no inverter or XOR cell appears there. While a pre-charge phase holds every rail input at 0, every rail output therefore stays at 0. When data is then evaluated, each rail can only rise. The first-share side is ordinary logic and does not depend on pre-charge.

The unmasked value of a lane is its first-share bit XOR its true-rail bit. A rail pair is valid when exactly one of its rails is 1, and it is pre-charged when both rails are 0.

Top module: `dr_mask_linear`

## Requirements
- R1: The inverter outputs the first share unchanged, puts the input complement rail on its true rail, and puts the input true rail on its complement rail.
- R2: For valid rail inputs, the exclusive-OR output has an unmasked value equal to the XOR of the two unmasked input values. Its first share equals the XOR of the two input first shares.
- R3: With valid rail inputs, the complement rail of the exclusive-OR output is the inverse of its true rail in every lane.
- R4: The selector passes operand B in every lane (first share and both rails) when select rails are (true=1, complement=0). It passes operand A when select rails are (true=0, complement=1).
- R5: With enable rails (true=1, complement=0), the gated exclusive-OR output has an unmasked value of A XOR B, and its complement rail is the inverse of its true rail.
- R6: With enable rails (true=0, complement=1), operand B has no effect: the gated exclusive-OR output has an unmasked value equal to A, and its rails stay complementary.
- R7: When every rail input is 0 (operand rails, select rails and enable rails), every rail output of every gadget is 0, whatever the first shares are.
- R8: When only the select rails are both 0, the selector's rail outputs are 0 even with valid operand rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_s1 | input | WIDTH | Operand A first share |
| a_t | input | WIDTH | Operand A second-share true rail |
| a_f | input | WIDTH | Operand A second-share complement rail |
| b_s1 | input | WIDTH | Operand B first share |
| b_t | input | WIDTH | Operand B second-share true rail |
| b_f | input | WIDTH | Operand B second-share complement rail |
| sel_t | input | 1 | Selector control true rail (1 selects B) |
| sel_f | input | 1 | Selector control complement rail (1 selects A) |
| en_t | input | 1 | Gate enable true rail (1 lets B through) |
| en_f | input | 1 | Gate enable complement rail (1 forces B to zero) |
| inv_s1 | output | WIDTH | Inverter first share |
| inv_t | output | WIDTH | Inverter true rail |
| inv_f | output | WIDTH | Inverter complement rail |
| sum_s1 | output | WIDTH | Exclusive-OR first share |
| sum_t | output | WIDTH | Exclusive-OR true rail |
| sum_f | output | WIDTH | Exclusive-OR complement rail |
| pick_s1 | output | WIDTH | Selector first share |
| pick_t | output | WIDTH | Selector true rail |
| pick_f | output | WIDTH | Selector complement rail |
| gsum_s1 | output | WIDTH | Gated exclusive-OR first share |
| gsum_t | output | WIDTH | Gated exclusive-OR true rail |
| gsum_f | output | WIDTH | Gated exclusive-OR complement rail |

## Verification
The block holds no state, so a wrong gate shows at the ports as soon as the inputs settle, within the same cycle. A swapped or wrong AND-OR term can break the unmasked value or the complementarity of a rail pair. It can also leave a rail at 1 during pre-charge. Each of these faults is seen in the cycle that applies the stimulus, so every gadget is checked under valid data, under a full pre-charge, and with only the select pre-charged. Every scalar combination is replicated across all lanes, and random vectors then exercise the lanes independently.

// File: rtl/dr_mask_pkg.sv
package dr_mask_pkg;

    // One lane of a masked value: first share plus second-share rail pair.
    typedef struct packed {
        logic s1;
        logic t;
        logic f;
    } dr_bit_t;

    // Public control in rail form (select or enable).
    typedef struct packed {
        logic on;
        logic off;
    } dr_ctl_t;

    function automatic dr_bit_t dr_xor_f(input dr_bit_t x, input dr_bit_t y);
        dr_bit_t r;
        r.s1 = x.s1 ^ y.s1;
        r.t  = (x.t & y.f) | (x.f & y.t);
        r.f  = (x.t & y.t) | (x.f & y.f);
        return r;
    endfunction

    function automatic dr_bit_t dr_mux_f(input dr_ctl_t c, input dr_bit_t d0, input dr_bit_t d1);
        dr_bit_t r;
        r.s1 = (c.on & d1.s1) | (c.off & d0.s1);
        r.t  = (c.on & d1.t)  | (c.off & d0.t);
        r.f  = (c.on & d1.f)  | (c.off & d0.f);
        return r;
    endfunction

    function automatic dr_bit_t dr_gate_f(input dr_ctl_t c, input dr_bit_t x);
        dr_bit_t r;
        r.s1 = c.on & x.s1;
        r.t  = c.on & x.t;
        r.f  = c.off | x.f;
        return r;
    endfunction

endpackage

// File: rtl/dr_xor_vec.sv
module dr_xor_vec
    import dr_mask_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_s1,
    input  logic [WIDTH-1:0] x_t,
    input  logic [WIDTH-1:0] x_f,
    input  logic [WIDTH-1:0] y_s1,
    input  logic [WIDTH-1:0] y_t,
    input  logic [WIDTH-1:0] y_f,
    output logic [WIDTH-1:0] z_s1,
    output logic [WIDTH-1:0] z_t,
    output logic [WIDTH-1:0] z_f
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        dr_bit_t xb, yb, zb;
        assign xb = '{s1: x_s1[i], t: x_t[i], f: x_f[i]};
        assign yb = '{s1: y_s1[i], t: y_t[i], f: y_f[i]};
        assign zb = dr_xor_f(xb, yb);
        assign z_s1[i] = zb.s1;
        assign z_t[i]  = zb.t;
        assign z_f[i]  = zb.f;
    end
endmodule

// File: rtl/dr_mux_vec.sv
module dr_mux_vec
    import dr_mask_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             c_on,
    input  logic             c_off,
    input  logic [WIDTH-1:0] d0_s1,
    input  logic [WIDTH-1:0] d0_t,
    input  logic [WIDTH-1:0] d0_f,
    input  logic [WIDTH-1:0] d1_s1,
    input  logic [WIDTH-1:0] d1_t,
    input  logic [WIDTH-1:0] d1_f,
    output logic [WIDTH-1:0] q_s1,
    output logic [WIDTH-1:0] q_t,
    output logic [WIDTH-1:0] q_f
);
    dr_ctl_t ctl;
    assign ctl = '{on: c_on, off: c_off};

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        dr_bit_t a0, a1, qb;
        assign a0 = '{s1: d0_s1[i], t: d0_t[i], f: d0_f[i]};
        assign a1 = '{s1: d1_s1[i], t: d1_t[i], f: d1_f[i]};
        assign qb = dr_mux_f(ctl, a0, a1);
        assign q_s1[i] = qb.s1;
        assign q_t[i]  = qb.t;
        assign q_f[i]  = qb.f;
    end
endmodule

// File: rtl/dr_gate_vec.sv
module dr_gate_vec
    import dr_mask_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             c_on,
    input  logic             c_off,
    input  logic [WIDTH-1:0] x_s1,
    input  logic [WIDTH-1:0] x_t,
    input  logic [WIDTH-1:0] x_f,
    output logic [WIDTH-1:0] q_s1,
    output logic [WIDTH-1:0] q_t,
    output logic [WIDTH-1:0] q_f
);
    dr_ctl_t ctl;
    assign ctl = '{on: c_on, off: c_off};

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        dr_bit_t xb, qb;
        assign xb = '{s1: x_s1[i], t: x_t[i], f: x_f[i]};
        assign qb = dr_gate_f(ctl, xb);
        assign q_s1[i] = qb.s1;
        assign q_t[i]  = qb.t;
        assign q_f[i]  = qb.f;
    end
endmodule

// File: rtl/dr_mask_linear.sv
module dr_mask_linear #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_s1,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] b_s1,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] b_f,
    input  logic             sel_t,
    input  logic             sel_f,
    input  logic             en_t,
    input  logic             en_f,
    output logic [WIDTH-1:0] inv_s1,
    output logic [WIDTH-1:0] inv_t,
    output logic [WIDTH-1:0] inv_f,
    output logic [WIDTH-1:0] sum_s1,
    output logic [WIDTH-1:0] sum_t,
    output logic [WIDTH-1:0] sum_f,
    output logic [WIDTH-1:0] pick_s1,
    output logic [WIDTH-1:0] pick_t,
    output logic [WIDTH-1:0] pick_f,
    output logic [WIDTH-1:0] gsum_s1,
    output logic [WIDTH-1:0] gsum_t,
    output logic [WIDTH-1:0] gsum_f
);
    // Inverter: rails swap, first share passes.
    assign inv_s1 = a_s1;
    assign inv_t  = a_f;
    assign inv_f  = a_t;

    dr_xor_vec #(.WIDTH(WIDTH)) u_xor (
        .x_s1(a_s1), .x_t(a_t), .x_f(a_f),
        .y_s1(b_s1), .y_t(b_t), .y_f(b_f),
        .z_s1(sum_s1), .z_t(sum_t), .z_f(sum_f)
    );

    dr_mux_vec #(.WIDTH(WIDTH)) u_mux (
        .c_on(sel_t), .c_off(sel_f),
        .d0_s1(a_s1), .d0_t(a_t), .d0_f(a_f),
        .d1_s1(b_s1), .d1_t(b_t), .d1_f(b_f),
        .q_s1(pick_s1), .q_t(pick_t), .q_f(pick_f)
    );

    logic [WIDTH-1:0] bg_s1, bg_t, bg_f;

    dr_gate_vec #(.WIDTH(WIDTH)) u_gate (
        .c_on(en_t), .c_off(en_f),
        .x_s1(b_s1), .x_t(b_t), .x_f(b_f),
        .q_s1(bg_s1), .q_t(bg_t), .q_f(bg_f)
    );

    dr_xor_vec #(.WIDTH(WIDTH)) u_gxor (
        .x_s1(a_s1), .x_t(a_t), .x_f(a_f),
        .y_s1(bg_s1), .y_t(bg_t), .y_f(bg_f),
        .z_s1(gsum_s1), .z_t(gsum_t), .z_f(gsum_f)
    );
endmodule

// File: rtl/dr_mask_linear_chk.sv
module dr_mask_linear_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_s1, a_t, a_f, b_s1, b_t, b_f,
    input logic             sel_t, sel_f, en_t, en_f,
    input logic [WIDTH-1:0] inv_s1, inv_t, inv_f,
    input logic [WIDTH-1:0] sum_s1, sum_t, sum_f,
    input logic [WIDTH-1:0] pick_s1, pick_t, pick_f,
    input logic [WIDTH-1:0] gsum_s1, gsum_t, gsum_f
);
    logic ops_ok, all_pre;
    assign ops_ok  = (&(a_t ^ a_f)) && (&(b_t ^ b_f));
    assign all_pre = ~|{a_t, a_f, b_t, b_f, sel_t, sel_f, en_t, en_f};

    always_comb begin
        AST_INV_SWAP: assert (inv_s1 == a_s1 && inv_t == a_f && inv_f == a_t); // R1
        if (ops_ok) begin
            AST_XOR_VALUE: assert ((sum_s1 ^ sum_t) == ((a_s1 ^ a_t) ^ (b_s1 ^ b_t))); // R2
            AST_XOR_RAILS: assert ((sum_t ^ sum_f) == '1); // R3
        end
        if (ops_ok && sel_t && !sel_f) begin
            AST_MUX_B: assert (pick_s1 == b_s1 && pick_t == b_t && pick_f == b_f); // R4
        end
        if (ops_ok && en_t && !en_f) begin
            AST_GXOR_ON: assert ((gsum_s1 ^ gsum_t) == ((a_s1 ^ a_t) ^ (b_s1 ^ b_t))); // R5
        end
        if (ops_ok && !en_t && en_f) begin
            AST_GXOR_OFF: assert ((gsum_s1 ^ gsum_t) == (a_s1 ^ a_t)); // R6
        end
        if (all_pre) begin
            AST_PRECHARGE: assert (~|{inv_t, inv_f, sum_t, sum_f, pick_t, pick_f, gsum_t, gsum_f}); // R7
        end
        if (!sel_t && !sel_f) begin
            AST_SEL_IDLE: assert (~|{pick_t, pick_f}); // R8
        end
    end
endmodule

bind dr_mask_linear dr_mask_linear_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dr_mask_linear_test.sv
module dr_mask_linear_test;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [W-1:0] a_s1, a_t, a_f, b_s1, b_t, b_f;
    logic sel_t, sel_f, en_t, en_f;
    logic [W-1:0] inv_s1, inv_t, inv_f, sum_s1, sum_t, sum_f;
    logic [W-1:0] pick_s1, pick_t, pick_f, gsum_s1, gsum_t, gsum_f;

    dr_mask_linear #(.WIDTH(W)) uut (.*);

    typedef struct {
        int           kind;   // 0 valid data, 1 full pre-charge, 2 select pre-charge
        logic [W-1:0] av, bv, a1, b1;
        logic         sel, en;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input int kind, input logic [W-1:0] as1, input logic [W-1:0] a2,
                         input logic [W-1:0] bs1, input logic [W-1:0] b2,
                         input logic sel, input logic en);
        item_t it;
        @(posedge clk);
        a_s1 <= as1; b_s1 <= bs1;
        if (kind == 1) begin
            a_t <= '0; a_f <= '0; b_t <= '0; b_f <= '0;
            sel_t <= 1'b0; sel_f <= 1'b0; en_t <= 1'b0; en_f <= 1'b0;
        end else begin
            a_t <= a2; a_f <= ~a2; b_t <= b2; b_f <= ~b2;
            sel_t <= (kind == 2) ? 1'b0 : sel; sel_f <= (kind == 2) ? 1'b0 : ~sel;
            en_t <= en; en_f <= ~en;
        end
        it.kind = kind; it.av = as1 ^ a2; it.bv = bs1 ^ b2;
        it.a1 = as1; it.b1 = bs1; it.sel = sel; it.en = en;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            logic [W-1:0] ev;
            it = q.pop_front();
            if (it.kind == 1) begin
                chk(~|{inv_t, inv_f, sum_t, sum_f}, "R7 inv/xor rails", {inv_t | sum_t}, '0);
                chk(~|{pick_t, pick_f, gsum_t, gsum_f}, "R7 mux/gxor rails", {pick_t | gsum_t}, '0);
            end else if (it.kind == 2) begin
                chk(~|{pick_t, pick_f}, "R8 select idle", pick_t | pick_f, '0);
            end else begin
                chk(inv_s1 == a_s1 && inv_t == a_f && inv_f == a_t, "R1 inverter", inv_s1 ^ inv_t, ~it.av);
                chk((sum_s1 ^ sum_t) == (it.av ^ it.bv) && sum_s1 == (it.a1 ^ it.b1),
                    "R2 xor value", sum_s1 ^ sum_t, it.av ^ it.bv);
                chk(sum_f == ~sum_t, "R3 xor rails", sum_f, ~sum_t);
                ev = it.sel ? it.bv : it.av;
                chk((pick_s1 ^ pick_t) == ev && pick_f == ~pick_t
                    && pick_s1 == (it.sel ? it.b1 : it.a1), "R4 selector", pick_s1 ^ pick_t, ev);
                ev = it.en ? (it.av ^ it.bv) : it.av;
                if (it.en)
                    chk((gsum_s1 ^ gsum_t) == ev && gsum_f == ~gsum_t, "R5 gated xor on", gsum_s1 ^ gsum_t, ev);
                else
                    chk((gsum_s1 ^ gsum_t) == ev && gsum_f == ~gsum_t, "R6 gated xor off", gsum_s1 ^ gsum_t, ev);
            end
        end
    end

    initial begin
        a_s1 = '0; a_t = '0; a_f = '0; b_s1 = '0; b_t = '0; b_f = '0;
        sel_t = 0; sel_f = 0; en_t = 0; en_f = 0;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        // Reset state: all rails idle, outputs idle (R7)
        @(negedge clk);
        chk(~|{inv_t, inv_f, sum_t, sum_f, pick_t, pick_f, gsum_t, gsum_f}, "R7 reset idle", sum_t, '0);
        // Every scalar combination replicated across lanes
        for (int k = 0; k < 64; k++) begin
            drive(0, {W{k[0]}}, {W{k[1]}}, {W{k[2]}}, {W{k[3]}}, k[4], k[5]);
        end
        // Pre-charge with arbitrary first shares
        for (int k = 0; k < 4; k++) begin
            drive(1, {W{k[0]}}, '0, {W{k[1]}}, '0, 1'b0, 1'b0);
            drive(2, {W{k[0]}}, {W{k[1]}}, {W{~k[0]}}, {W{~k[1]}}, 1'b0, k[0]);
        end
        // Random wide vectors
        for (int k = 0; k < 200; k++) begin
            drive(0, W'($urandom), W'($urandom), W'($urandom), W'($urandom),
                  1'($urandom), 1'($urandom));
            if (k % 20 == 0) drive(1, W'($urandom), '0, W'($urandom), '0, 1'b0, 1'b0);
        end
        repeat (3) @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule